// File: doc/BRIEF.md
# Garbage-Collection Victim Selector

This block tracks, for every erase block of a flash array, how many pages hold live data, how many hold stale data, and when the block was last changed. It watches the free-block count supplied by the allocator. When free space runs low, it starts a reclamation run and names the blocks that should be emptied and erased. The copying of live pages, the erase commands and the logical-to-physical mapping belong to other blocks. This block only picks victims and puts them in order.

A single event port reports page programs, page invalidations and finished erases, one event per clock. Time is a logical counter that advances by one on every accepted program or invalidate event. A block's age is the distance between that counter and the stamp taken at the block's last change, modulo 2^AGE_W.

A run is made of scans. Each scan visits every block once, one block per clock, and ends with a one-cycle done pulse. The pulse carries a victim when one exists. Two ranking rules are available:
- Greedy: the most stale pages wins.
- Cost-benefit: age·(1−u)/(2u) wins, where u is the live fraction of the block. The score is evaluated by cross-multiplication, with no divider.

Each victim is held as pending, so later scans skip it, until its erase is reported. Scans repeat back-to-back until free plus pending blocks reach the refill target.

Top module: `gc_victim_sel`

## Requirements
- R1: While idle, `start` pulses for one cycle in the cycle after `free_cnt` plus the number of pending victims is below LOW_MARK (default 3). No run starts when that sum is LOW_MARK or more. All outputs are 0 after reset.
- R2: `done` pulses for one cycle exactly NUM_BLK cycles after `start`, and NUM_BLK cycles after the previous `done` when a run continues.
- R3: With `policy` = 0 (greedy), the victim is the eligible block with the most invalid pages.
- R4: With `policy` = 1 (cost-benefit), the victim is the eligible block with the highest age·(PAGES−valid)/valid. Block a beats block b when age_a·(PAGES−v_a)·v_b > age_b·(PAGES−v_b)·v_a.
- R5: Under either policy, an eligible block with zero valid pages is chosen before any block that still holds valid pages.
- R6: A block is not eligible if it is free (zero valid and zero invalid pages), if it is the block on `open_blk`, or if it is pending (already issued and not yet erased).
- R7: Among equally ranked candidates, the lowest block index wins.
- R8: `victim_vld` is asserted only together with `done`, and the issued block becomes pending. The run continues with a new scan while a victim was found and `free_cnt` + pending is below TARGET (default 5). A scan that finds no eligible block ends the run with `done` and no victim.
- R9: Event encoding on `ev_op`: 2'b00 programs a page, 2'b01 invalidates a page, 2'b10 reports an erase, and 2'b11 does nothing. A program adds one valid page and is ignored when the block's valid plus invalid pages equal PAGES. An invalidate moves one page from valid to invalid and is ignored when the block has no valid pages. An erase clears both counts and the pending mark.
- R10: Each accepted program or invalidate stamps its block with the current logical time and then advances that time by one. A block's age is the current time minus its stamp, modulo 2^AGE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_vld | input | 1 | Event strobe |
| ev_op | input | 2 | Event kind (program, invalidate, erase, none) |
| ev_blk | input | BLK_W | Block the event refers to |
| free_cnt | input | CNT_W | Current number of free blocks |
| open_blk | input | BLK_W | Block currently open for writing, never selected |
| policy | input | 1 | 0 greedy, 1 cost-benefit |
| start | output | 1 | Reclamation run begins |
| done | output | 1 | A scan has finished |
| victim_vld | output | 1 | `victim_idx` holds a new victim |
| victim_idx | output | BLK_W | Selected block |

## Verification
The bench builds block populations in which the greedy and cost-benefit rankings disagree. One population has old half-full blocks next to young nearly-stale ones, so a swap of the policies or an error in the age arithmetic changes the victim order. Other patterns place equal stale counts at two indices, a fully stale block beside a block with more stale pages, and an open block next to a free one. These separate the tie rule, the zero-valid priority and the exclusions. Runs with free counts at and just below the trigger level, and runs that exhaust the eligible blocks, show when runs start, continue and stop. An over-invalidated block shows whether the ignore rule for empty blocks holds.

// File: rtl/gc_pkg.sv
// Shared types for the victim selector.
// Assumes: at most one event per clock on the event port.
package gc_pkg;
    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_INV   = 2'b01,
        OP_ERASE = 2'b10,
        OP_NONE  = 2'b11
    } gc_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } gc_st_e;
endpackage

// File: rtl/gc_blk_table.sv
// Per-block bookkeeping: valid/invalid page counters, last-change stamps,
// pending marks and the logical clock. Offers one combinational read port.
// Assumes: ev_blk and mark_blk are below NUM_BLK.
module gc_blk_table #(
    parameter  int NUM_BLK = 16,
    parameter  int PAGES   = 8,
    parameter  int AGE_W   = 10,
    localparam int BLK_W   = $clog2(NUM_BLK),
    localparam int PG_W    = $clog2(PAGES + 1),
    localparam int CNT_W   = $clog2(NUM_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_vld,
    input  logic [1:0]       ev_op,
    input  logic [BLK_W-1:0] ev_blk,
    input  logic             mark_vld,
    input  logic [BLK_W-1:0] mark_blk,
    input  logic [BLK_W-1:0] rd_idx,
    output logic [PG_W-1:0]  rd_valid,
    output logic [PG_W-1:0]  rd_invalid,
    output logic [AGE_W-1:0] rd_age,
    output logic             rd_pend,
    output logic [CNT_W-1:0] pend_cnt
);
    import gc_pkg::*;

    logic [PG_W-1:0]    vcnt_q  [NUM_BLK];
    logic [PG_W-1:0]    icnt_q  [NUM_BLK];
    logic [AGE_W-1:0]   stamp_q [NUM_BLK];
    logic [NUM_BLK-1:0] pend_q;
    logic [AGE_W-1:0]   now_q;
    logic [PG_W:0]      used;

    // Pages in use in the block addressed by the current event.
    assign used = {1'b0, vcnt_q[ev_blk]} + {1'b0, icnt_q[ev_blk]};

    // Apply page events and erase completions, then set pending marks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BLK; b++) begin
                vcnt_q[b]  <= '0;
                icnt_q[b]  <= '0;
                stamp_q[b] <= '0;
            end
            pend_q <= '0;
            now_q  <= '0;
        end else begin
            if (ev_vld) begin
                case (gc_op_e'(ev_op))
                    OP_PROG: begin
                        if (used < (PG_W+1)'(PAGES)) begin
                            vcnt_q[ev_blk]  <= vcnt_q[ev_blk] + 1'b1;
                            stamp_q[ev_blk] <= now_q;
                            now_q           <= now_q + 1'b1;
                        end
                    end
                    OP_INV: begin
                        if (vcnt_q[ev_blk] != '0) begin
                            vcnt_q[ev_blk]  <= vcnt_q[ev_blk] - 1'b1;
                            icnt_q[ev_blk]  <= icnt_q[ev_blk] + 1'b1;
                            stamp_q[ev_blk] <= now_q;
                            now_q           <= now_q + 1'b1;
                        end
                    end
                    OP_ERASE: begin
                        vcnt_q[ev_blk]  <= '0;
                        icnt_q[ev_blk]  <= '0;
                        stamp_q[ev_blk] <= now_q;
                        pend_q[ev_blk]  <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (mark_vld) pend_q[mark_blk] <= 1'b1;
        end
    end

    // Count the pending victims.
    always_comb begin
        pend_cnt = '0;
        for (int b = 0; b < NUM_BLK; b++) pend_cnt = pend_cnt + CNT_W'(pend_q[b]);
    end

    assign rd_valid   = vcnt_q[rd_idx];
    assign rd_invalid = icnt_q[rd_idx];
    assign rd_age     = now_q - stamp_q[rd_idx];
    assign rd_pend    = pend_q[rd_idx];
endmodule

// File: rtl/gc_score_cmp.sv
// Decides whether a candidate block outranks the best block seen so far.
// Zero-valid blocks rank first. Then greedy compares stale counts and
// cost-benefit compares age*(PAGES-v) cross-multiplied with the other's v.
// Strict comparison keeps the earlier (lower) index on ties.
module gc_score_cmp #(
    parameter  int PAGES = 8,
    parameter  int AGE_W = 10,
    localparam int PG_W  = $clog2(PAGES + 1),
    localparam int PW    = AGE_W + 2 * PG_W
) (
    input  logic             policy,
    input  logic [PG_W-1:0]  c_valid,
    input  logic [PG_W-1:0]  c_invalid,
    input  logic [AGE_W-1:0] c_age,
    input  logic             b_found,
    input  logic [PG_W-1:0]  b_valid,
    input  logic [PG_W-1:0]  b_invalid,
    input  logic [AGE_W-1:0] b_age,
    output logic             better
);
    logic [PW-1:0] lhs, rhs;
    logic          c_zero, b_zero;

    // Cost-benefit products and the ranking decision.
    always_comb begin
        c_zero = (c_valid == '0);
        b_zero = (b_valid == '0);
        lhs = PW'(c_age) * PW'(PG_W'(PAGES) - c_valid) * PW'(b_valid);
        rhs = PW'(b_age) * PW'(PG_W'(PAGES) - b_valid) * PW'(c_valid);
        if (!b_found)             better = 1'b1;
        else if (c_zero != b_zero) better = c_zero;
        else if (c_zero)          better = 1'b0;
        else if (!policy)         better = (c_invalid > b_invalid);
        else                      better = (lhs > rhs);
    end
endmodule

// File: rtl/gc_scan_seq.sv
// Run/scan sequencer: triggers on low free space, walks every block once
// per scan, keeps the best candidate, issues it and repeats until the refill
// target is met or nothing is eligible.
// Assumes: open_blk and policy stay put during a scan.
module gc_scan_seq #(
    parameter  int NUM_BLK  = 16,
    parameter  int PAGES    = 8,
    parameter  int AGE_W    = 10,
    parameter  int LOW_MARK = 3,
    parameter  int TARGET   = 5,
    localparam int BLK_W    = $clog2(NUM_BLK),
    localparam int PG_W     = $clog2(PAGES + 1),
    localparam int CNT_W    = $clog2(NUM_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic [CNT_W-1:0] pend_cnt,
    input  logic [BLK_W-1:0] open_blk,
    input  logic [PG_W-1:0]  rd_valid,
    input  logic [PG_W-1:0]  rd_invalid,
    input  logic [AGE_W-1:0] rd_age,
    input  logic             rd_pend,
    input  logic             better,
    output logic [BLK_W-1:0] rd_idx,
    output logic             best_found,
    output logic [PG_W-1:0]  best_valid,
    output logic [PG_W-1:0]  best_invalid,
    output logic [AGE_W-1:0] best_age,
    output logic             mark_vld,
    output logic [BLK_W-1:0] mark_blk,
    output logic             start,
    output logic             done,
    output logic             victim_vld,
    output logic [BLK_W-1:0] victim_idx
);
    import gc_pkg::*;

    localparam logic [BLK_W-1:0] LAST = BLK_W'(NUM_BLK - 1);

    gc_st_e           st_q;
    logic [BLK_W-1:0] idx_q, best_idx_q;
    logic             elig, take, fin_found;
    logic [BLK_W-1:0] fin_idx;
    logic [CNT_W:0]   bank;

    // Eligibility of the scanned block and the scan's running result.
    always_comb begin
        elig      = !rd_pend && (rd_valid != '0 || rd_invalid != '0) && (idx_q != open_blk);
        take      = (st_q == ST_SCAN) && elig && better;
        fin_found = best_found || take;
        fin_idx   = take ? idx_q : best_idx_q;
        bank      = {1'b0, free_cnt} + {1'b0, pend_cnt};
    end

    assign rd_idx   = idx_q;
    assign mark_vld = (st_q == ST_SCAN) && (idx_q == LAST) && fin_found;
    assign mark_blk = fin_idx;

    // Run state, scan index, best candidate and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            idx_q        <= '0;
            best_found   <= 1'b0;
            best_idx_q   <= '0;
            best_valid   <= '0;
            best_invalid <= '0;
            best_age     <= '0;
            start        <= 1'b0;
            done         <= 1'b0;
            victim_vld   <= 1'b0;
            victim_idx   <= '0;
        end else begin
            start      <= 1'b0;
            done       <= 1'b0;
            victim_vld <= 1'b0;
            if (st_q == ST_IDLE) begin
                if (bank < (CNT_W+1)'(LOW_MARK)) begin
                    start      <= 1'b1;
                    st_q       <= ST_SCAN;
                    idx_q      <= '0;
                    best_found <= 1'b0;
                end
            end else begin
                if (take) begin
                    best_found   <= 1'b1;
                    best_idx_q   <= idx_q;
                    best_valid   <= rd_valid;
                    best_invalid <= rd_invalid;
                    best_age     <= rd_age;
                end
                if (idx_q == LAST) begin
                    done       <= 1'b1;
                    victim_vld <= fin_found;
                    if (fin_found) victim_idx <= fin_idx;
                    idx_q      <= '0;
                    best_found <= 1'b0;
                    if (!(fin_found && (bank + 1'b1) < (CNT_W+1)'(TARGET))) st_q <= ST_IDLE;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gc_victim_sel.sv
// Top of the garbage-collection victim selector: block table, ranking
// comparator and scan sequencer.
// Assumes: one event per clock, and events held off while a scan runs.
module gc_victim_sel #(
    parameter  int NUM_BLK  = 16,
    parameter  int PAGES    = 8,
    parameter  int AGE_W    = 10,
    parameter  int LOW_MARK = 3,
    parameter  int TARGET   = 5,
    localparam int BLK_W    = $clog2(NUM_BLK),
    localparam int PG_W     = $clog2(PAGES + 1),
    localparam int CNT_W    = $clog2(NUM_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_vld,
    input  logic [1:0]       ev_op,
    input  logic [BLK_W-1:0] ev_blk,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic [BLK_W-1:0] open_blk,
    input  logic             policy,
    output logic             start,
    output logic             done,
    output logic             victim_vld,
    output logic [BLK_W-1:0] victim_idx
);
    logic [BLK_W-1:0] rd_idx, mark_blk;
    logic [PG_W-1:0]  rd_valid, rd_invalid, best_valid, best_invalid;
    logic [AGE_W-1:0] rd_age, best_age;
    logic             rd_pend, best_found, better, mark_vld;
    logic [CNT_W-1:0] pend_cnt;

    gc_blk_table #(.NUM_BLK(NUM_BLK), .PAGES(PAGES), .AGE_W(AGE_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_op(ev_op), .ev_blk(ev_blk),
        .mark_vld(mark_vld), .mark_blk(mark_blk), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_invalid(rd_invalid), .rd_age(rd_age),
        .rd_pend(rd_pend), .pend_cnt(pend_cnt)
    );

    gc_score_cmp #(.PAGES(PAGES), .AGE_W(AGE_W)) u_cmp (
        .policy(policy), .c_valid(rd_valid), .c_invalid(rd_invalid), .c_age(rd_age),
        .b_found(best_found), .b_valid(best_valid), .b_invalid(best_invalid),
        .b_age(best_age), .better(better)
    );

    gc_scan_seq #(.NUM_BLK(NUM_BLK), .PAGES(PAGES), .AGE_W(AGE_W),
                  .LOW_MARK(LOW_MARK), .TARGET(TARGET)) u_seq (
        .clk(clk), .rst_n(rst_n), .free_cnt(free_cnt), .pend_cnt(pend_cnt),
        .open_blk(open_blk), .rd_valid(rd_valid), .rd_invalid(rd_invalid),
        .rd_age(rd_age), .rd_pend(rd_pend), .better(better), .rd_idx(rd_idx),
        .best_found(best_found), .best_valid(best_valid), .best_invalid(best_invalid),
        .best_age(best_age), .mark_vld(mark_vld), .mark_blk(mark_blk),
        .start(start), .done(done), .victim_vld(victim_vld), .victim_idx(victim_idx)
    );
endmodule

// File: rtl/gc_victim_sel_chk.sv
// Protocol checker for the victim selector, bound to every instance.
// Assumes: the same parameter values as the bound instance.
module gc_victim_sel_chk #(
    parameter  int NUM_BLK  = 16,
    parameter  int LOW_MARK = 3,
    localparam int CNT_W    = $clog2(NUM_BLK + 1),
    localparam int CW       = $clog2(NUM_BLK + 2) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] free_cnt,
    input logic             start,
    input logic             done,
    input logic             victim_vld
);
    logic [CW-1:0] since_q;

    // Cycles since the last start or done pulse, held once past one scan.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    since_q <= '0;
        else if (start || done)                        since_q <= CW'(1);
        else if (since_q != '0 && since_q <= CW'(NUM_BLK)) since_q <= since_q + 1'b1;
    end

    a_r1_start_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ($past(free_cnt) < CNT_W'(LOW_MARK)));
    a_r1_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    a_r2_scan_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_q == CW'(NUM_BLK)));
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_victim_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        victim_vld |-> done);
endmodule

bind gc_victim_sel gc_victim_sel_chk #(.NUM_BLK(NUM_BLK), .LOW_MARK(LOW_MARK)) u_chk (
    .clk(clk), .rst_n(rst_n), .free_cnt(free_cnt), .start(start),
    .done(done), .victim_vld(victim_vld)
);

// File: tb/sim_gc_victim_sel.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every clock, plus directed
// victim-order checks for each requirement.
module sim_gc_victim_sel;
    localparam int N     = 16;
    localparam int P     = 8;
    localparam int AW    = 10;
    localparam int LOW   = 3;
    localparam int TGT   = 5;
    localparam int BW    = $clog2(N);
    localparam int CW    = $clog2(N + 1);
    localparam int AMASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_vld = 1'b0;
    logic [1:0]    ev_op = 2'b11;
    logic [BW-1:0] ev_blk = '0;
    logic [CW-1:0] free_cnt = CW'(N);
    logic [BW-1:0] open_blk = BW'(15);
    logic          policy = 1'b0;
    logic          start, done, victim_vld;
    logic [BW-1:0] victim_idx;

    int n_chk = 0, n_err = 0, n_start = 0, n_done = 0;
    int got_q[$];
    string cur_req = "R3";
    bit finished = 0;

    // Reference model state.
    int mv[N], mi[N], ms[N], mp[N];
    int mnow, m_state, m_pos, e_vidx;
    bit e_start, e_done, e_vv;

    gc_victim_sel #(.NUM_BLK(N), .PAGES(P), .AGE_W(AW), .LOW_MARK(LOW), .TARGET(TGT)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_op(ev_op), .ev_blk(ev_blk),
        .free_cnt(free_cnt), .open_blk(open_blk), .policy(policy),
        .start(start), .done(done), .victim_vld(victim_vld), .victim_idx(victim_idx)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mage(input int b);
        return (mnow - ms[b]) & AMASK;
    endfunction

    function automatic int mpend();
        int c = 0;
        for (int b = 0; b < N; b++) c += mp[b];
        return c;
    endfunction

    // Ranking from the requirements: zero-valid first, then policy, low index on ties.
    function automatic int pick();
        int best = -1;
        for (int b = 0; b < N; b++) begin
            if (mp[b] == 0 && (mv[b] + mi[b]) > 0 && b != int'(open_blk)) begin
                if (best < 0) best = b;
                else if (mv[b] == 0 && mv[best] != 0) best = b;
                else if (mv[b] != 0 && mv[best] != 0) begin
                    if (!policy) begin
                        if (mi[b] > mi[best]) best = b;
                    end else if (mage(b) * (P - mv[b]) * mv[best] >
                                 mage(best) * (P - mv[best]) * mv[b]) best = b;
                end
            end
        end
        return best;
    endfunction

    // Reference model, stepped on every rising edge.
    always @(posedge clk) begin
        int v;
        v = -1;
        if (!rst_n) begin
            for (int b = 0; b < N; b++) begin mv[b] = 0; mi[b] = 0; ms[b] = 0; mp[b] = 0; end
            mnow = 0; m_state = 0; m_pos = 0; e_vidx = 0;
            e_start = 0; e_done = 0; e_vv = 0;
        end else begin
            e_start = 0; e_done = 0; e_vv = 0;
            if (m_state == 0) begin
                if (int'(free_cnt) + mpend() < LOW) begin
                    e_start = 1; m_state = 1; m_pos = 0;
                end
            end else if (m_pos == N - 1) begin
                v = pick();
                e_done = 1;
                if (v >= 0) begin e_vv = 1; e_vidx = v; end
                if (!(v >= 0 && int'(free_cnt) + mpend() + 1 < TGT)) m_state = 0;
                m_pos = 0;
            end else m_pos++;
            if (ev_vld) begin
                case (ev_op)
                    2'b00: if (mv[ev_blk] + mi[ev_blk] < P) begin
                        mv[ev_blk]++; ms[ev_blk] = mnow; mnow = (mnow + 1) & AMASK;
                    end
                    2'b01: if (mv[ev_blk] > 0) begin
                        mv[ev_blk]--; mi[ev_blk]++; ms[ev_blk] = mnow; mnow = (mnow + 1) & AMASK;
                    end
                    2'b10: begin mv[ev_blk] = 0; mi[ev_blk] = 0; mp[ev_blk] = 0; ms[ev_blk] = mnow; end
                    default: ;
                endcase
            end
            if (v >= 0) mp[v] = 1;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(start === e_start, "R1 start", int'(start), int'(e_start));
            chk(done === e_done, "R2 done", int'(done), int'(e_done));
            chk(victim_vld === e_vv, "R8 victim_vld", int'(victim_vld), int'(e_vv));
            if (e_vv) chk(int'(victim_idx) == e_vidx, cur_req, int'(victim_idx), e_vidx);
            if (start) n_start++;
            if (done) n_done++;
            if (victim_vld) got_q.push_back(int'(victim_idx));
        end
    end

    task automatic ev(input logic [1:0] op, input int b, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ev_vld = 1'b1; ev_op = op; ev_blk = BW'(b);
            @(negedge clk); ev_vld = 1'b0;
        end
    endtask

    task automatic run_gc(input int f);
        got_q.delete(); n_start = 0; n_done = 0;
        @(negedge clk); free_cnt = CW'(f);
        repeat (4 * (N + 1) + 4) @(negedge clk);
        free_cnt = CW'(N);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_victims(input string req, input int n, input int e0, input int e1, input int e2);
        int e[3];
        e[0] = e0; e[1] = e1; e[2] = e2;
        chk(got_q.size() == n, {req, " victim count"}, got_q.size(), n);
        for (int k = 0; k < n && k < got_q.size(); k++)
            chk(got_q[k] == e[k], {req, " victim order"}, got_q[k], e[k]);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start === 1'b0 && done === 1'b0 && victim_vld === 1'b0, "R1 reset outputs",
            int'({start, done, victim_vld}), 0);

        // R3/R7: greedy with a tie on stale counts at blocks 5 and 9.
        cur_req = "R3 R7 greedy";
        ev(2'b00, 2, 6); ev(2'b01, 2, 2);
        ev(2'b00, 5, 8); ev(2'b01, 5, 5);
        ev(2'b00, 9, 8); ev(2'b01, 9, 5);
        ev(2'b00, 11, 3);
        run_gc(3);
        chk(n_start == 0, "R1 no start at LOW_MARK", n_start, 0);
        run_gc(2);
        chk(n_start == 1, "R1 one run", n_start, 1);
        expect_victims("R3 R7", 3, 5, 9, 2);
        ev(2'b10, 5, 1); ev(2'b10, 9, 1); ev(2'b10, 2, 1);

        // R5: a fully stale block beats one with more stale pages.
        cur_req = "R5 zero valid first";
        ev(2'b00, 3, 4); ev(2'b01, 3, 1);
        ev(2'b00, 7, 2); ev(2'b01, 7, 2);
        ev(2'b00, 12, 8); ev(2'b01, 12, 7);
        run_gc(2);
        expect_victims("R5", 3, 7, 12, 3);
        ev(2'b10, 7, 1); ev(2'b10, 12, 1); ev(2'b10, 3, 1); ev(2'b10, 11, 1);

        // R4/R10: old half-full block outscores young stale ones (greedy would give 4,1,14).
        cur_req = "R4 R10 cost-benefit";
        policy = 1'b1;
        ev(2'b00, 1, 8); ev(2'b01, 1, 4);
        ev(2'b00, 4, 8); ev(2'b01, 4, 6);
        ev(2'b00, 14, 1);
        run_gc(2);
        expect_victims("R4 R10", 3, 1, 14, 4);
        ev(2'b10, 1, 1); ev(2'b10, 14, 1); ev(2'b10, 4, 1);
        policy = 1'b0;

        // R6/R8: open block and pending block skipped; run ends on an empty scan.
        cur_req = "R6 exclusion";
        open_blk = BW'(8);
        ev(2'b00, 6, 3);
        ev(2'b00, 8, 2); ev(2'b01, 8, 1);
        run_gc(2);
        expect_victims("R6", 1, 6, 0, 0);
        chk(n_done == 2, "R8 empty scan ends run", n_done, 2);
        open_blk = BW'(15);
        ev(2'b10, 6, 1); ev(2'b10, 8, 1);

        // R9: extra invalidates on an empty block are ignored.
        cur_req = "R9 counters";
        ev(2'b00, 9, 4); ev(2'b01, 9, 6);
        ev(2'b00, 2, 8); ev(2'b01, 2, 6);
        ev(2'b11, 2, 1);
        run_gc(2);
        expect_victims("R9", 2, 9, 2, 0);
        chk(n_done == 3, "R8 scans until none eligible", n_done, 3);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule